// File: doc/BRIEF.md
# Speculative Two-Level Switch Allocator

This block decides, cycle by cycle, which input of a five-port router may drive each output through the crossbar. Two kinds of claim compete for an output. An input with no packet in progress can place a tentative claim on the output its predictor names. If a head flit arrives while that claim is held, the flit crosses at once and skips route computation and allocation. An input whose head flit has a computed route places a firm claim. A firm claim always beats a tentative one, and it takes away an existing tentative reservation in the same cycle.

In the cycle after a speculative crossing, the real route of the head flit arrives on the `route` input. If it matches the reserved output, the input keeps the output for the rest of the packet. If it does not match, the block raises a one-cycle `kill` on the output that carried the wrong flit, so the next stage drops it. The flit then takes the normal path: a firm request on the correct output, then traversal. Each input runs a state machine with these states: IDLE, RSV (reservation held), SPEC (verifying a speculative crossing), RC (route being computed), SA (firm request pending) and XFER (output owned, packet streaming). These are the transitions:
- IDLE to RSV on a tentative win.
- IDLE to RC on a head arrival.
- RSV to SPEC on a head arrival.
- RSV to RC or IDLE when a firm claim withdraws the reservation.
- RSV to IDLE when the prediction is dropped or changes.
- SPEC to XFER on a hit.
- SPEC to IDLE on a hit for a single-flit packet.
- SPEC to SA on a miss.
- RC to SA in every case.
- SA to XFER on a firm win.
- XFER to IDLE when the tail crosses.

Each output has one round-robin pointer.

Top module: `spec_sw_alloc`

## Requirements
- R1: While reset is active and in the first cycle after it, `in_go`, `xbar_vld` and `kill` are all zero, and every input is idle.
- R2: Port numbers are local 0, east 1, west 2, north 3 and south 4, and `xbar_sel` carries the number of the input. An idle input may raise `tent_req` with no head arriving, naming a free output in `pred_port`. If no firm request and no other reservation exists for that output, the input holds a reservation from the next cycle. A head flit (`flit_vld` and `flit_head`) that arrives while the reservation is held crosses in its arrival cycle: `in_go[i]`=1, `xbar_vld[p]`=1 and `xbar_sel[p]`=i.
- R3: A firm request on a free output wins over all tentative requests. A reservation on that output is withdrawn in the same cycle, so a head that arrives at the holder in that cycle does not cross and goes on to route computation.
- R4: In the cycle after a speculative crossing, if `route[i]` equals the reserved output, no kill is raised and the output stays with the input. No flit crosses in that cycle. Later flits cross from the following cycle. A single-flit packet releases the output.
- R5: In the cycle after a speculative crossing, if `route[i]` differs from the reserved output, `kill` is high on that output's bit for exactly that one cycle, and its other bits stay low.
- R6: When uncontended, a head flit crosses on its routed output three cycles after it arrives at an idle input without a reservation. After a miss, it crosses three cycles after its speculative crossing.
- R7: Each output is driven by at most one input per cycle, and the number of set `in_go` bits equals the number of set `xbar_vld` bits.
- R8: A granted output stays with its input until the tail flit crosses. Meanwhile a flit crosses in each cycle that `flit_vld` is high, `in_go` is never set without `flit_vld`, and other inputs wait.
- R9: Among firm requesters for an output, the first input at or after that output's pointer, in ascending order with wrap, wins, and the pointer then moves to one past the winner. Tentative grants use the same order but do not move the pointer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| tent_req | input | 5 | Per input: predictor wants a tentative reservation |
| pred_port | input | 5x3 | Per input: predicted output number |
| flit_vld | input | 5 | Per input: a flit waits at the buffer head |
| flit_head | input | 5 | Per input: waiting flit is a head flit |
| flit_tail | input | 5 | Per input: waiting flit is a tail flit |
| route | input | 5x3 | Per input: computed output of the head flit, valid the cycle after it arrives |
| in_go | output | 5 | Per input: waiting flit crosses this cycle |
| xbar_vld | output | 5 | Per output: crossbar column carries a flit |
| xbar_sel | output | 5x3 | Per output: input number driving the column |
| kill | output | 5 | Per output: drop the flit sent in the previous cycle |

## Verification
The hardest case to reach is a reservation that is withdrawn in the very cycle its holder's head flit arrives. To get there, another input must have walked through route computation to a firm request on the same output in exactly that cycle. The bench therefore starts the competing head two cycles before the holder's head. A second hard case is telling round-robin order apart from fixed priority. To do that, the bench first lets a middle-numbered input win an output, which moves the pointer, and then makes a high-numbered input and a low-numbered input contend for it. A long run with random inputs is then compared on every clock with a behavioural model kept in the bench.

// File: rtl/sa_pkg.sv
package sa_pkg;
    typedef enum logic [2:0] {
        S_IDLE,
        S_RSV,
        S_SPEC,
        S_RC,
        S_SA,
        S_XFER
    } sa_state_e;
endpackage

// File: rtl/sa_input_fsm.sv
module sa_input_fsm
    import sa_pkg::*;
#(
    parameter int PW = 3
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          tent_req,
    input  logic [PW-1:0] pred_port,
    input  logic          flit_vld,
    input  logic          flit_head,
    input  logic          flit_tail,
    input  logic [PW-1:0] route,
    input  logic          firm_won,
    input  logic          tent_won,
    input  logic          rsv_lost,
    output logic          tent_vld,
    output logic          firm_vld,
    output logic          hold_vld,
    output logic          own_vld,
    output logic          drive_vld,
    output logic          kill_vld,
    output logic [PW-1:0] cur_port
);
    sa_state_e     state_q, state_d;
    logic [PW-1:0] port_q, port_d;
    logic          tail_q, tail_d;
    logic          head_arr;
    logic          hit;

    assign head_arr = flit_vld & flit_head;
    assign hit      = (route == port_q);
    assign cur_port = port_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= S_IDLE;
            port_q  <= '0;
            tail_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            port_q  <= port_d;
            tail_q  <= tail_d;
        end
    end

    // next-state process
    always_comb begin
        state_d = state_q;
        port_d  = port_q;
        tail_d  = tail_q;
        unique case (state_q)
            S_IDLE: begin
                if (head_arr) begin
                    state_d = S_RC;
                end else if (tent_won) begin
                    state_d = S_RSV;
                    port_d  = pred_port;
                end
            end
            S_RSV: begin
                if (rsv_lost) begin
                    state_d = head_arr ? S_RC : S_IDLE;
                end else if (head_arr) begin
                    state_d = S_SPEC;
                    tail_d  = flit_tail;
                end else if (!tent_req || (pred_port != port_q)) begin
                    state_d = S_IDLE;
                end
            end
            S_SPEC: begin
                if (hit) begin
                    state_d = tail_q ? S_IDLE : S_XFER;
                end else begin
                    state_d = S_SA;
                    port_d  = route;
                end
            end
            S_RC: begin
                state_d = S_SA;
                port_d  = route;
            end
            S_SA: begin
                if (firm_won) state_d = S_XFER;
            end
            S_XFER: begin
                if (flit_vld && flit_tail) state_d = S_IDLE;
            end
            default: state_d = S_IDLE;
        endcase
    end

    // output process
    always_comb begin
        tent_vld  = 1'b0;
        firm_vld  = 1'b0;
        hold_vld  = 1'b0;
        own_vld   = 1'b0;
        drive_vld = 1'b0;
        kill_vld  = 1'b0;
        unique case (state_q)
            S_IDLE: tent_vld = tent_req & ~head_arr;
            S_RSV: begin
                hold_vld  = 1'b1;
                drive_vld = head_arr & ~rsv_lost;
            end
            S_SPEC: begin
                own_vld  = 1'b1;
                kill_vld = ~hit;
            end
            S_RC: ;
            S_SA: firm_vld = 1'b1;
            S_XFER: begin
                own_vld   = 1'b1;
                drive_vld = flit_vld;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/sa_out_arb.sv
module sa_out_arb #(
    parameter int NP = 5,
    parameter int PW = 3
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [NP-1:0] firm_req,
    input  logic [NP-1:0] tent_req,
    input  logic [NP-1:0] hold_req,
    input  logic [NP-1:0] own_req,
    output logic [NP-1:0] firm_gnt,
    output logic [NP-1:0] tent_gnt,
    output logic          firm_pres
);
    logic [PW-1:0] ptr_q, ptr_d;
    logic          busy;
    logic [PW-1:0] win;

    function automatic logic [NP-1:0] rr_pick(input logic [NP-1:0] req,
                                              input logic [PW-1:0] ptr);
        logic [NP-1:0] g;
        logic [PW:0]   sum;
        logic [PW-1:0] idx;
        g = '0;
        for (int k = 0; k < NP; k++) begin
            sum = {1'b0, ptr} + (PW+1)'(k);
            if (sum >= (PW+1)'(NP)) sum = sum - (PW+1)'(NP);
            idx = sum[PW-1:0];
            if (req[idx] && (g == '0)) g[idx] = 1'b1;
        end
        return g;
    endfunction

    assign busy      = |own_req;
    assign firm_pres = ~busy & (|firm_req);

    always_comb begin
        firm_gnt = '0;
        tent_gnt = '0;
        if (firm_pres) begin
            firm_gnt = rr_pick(firm_req, ptr_q);
        end else if (!busy && !(|hold_req)) begin
            tent_gnt = rr_pick(tent_req, ptr_q);
        end
    end

    always_comb begin
        win = '0;
        for (int j = 0; j < NP; j++) begin
            if (firm_gnt[j]) win = PW'(j);
        end
        ptr_d = ptr_q;
        if (firm_pres) ptr_d = (win == PW'(NP-1)) ? '0 : win + PW'(1);
    end

    always_ff @(posedge clk) begin
        if (rst) ptr_q <= '0;
        else     ptr_q <= ptr_d;
    end
endmodule

// File: rtl/spec_sw_alloc.sv
module spec_sw_alloc #(
    parameter  int NUM_PORTS = 5,
    localparam int PW        = $clog2(NUM_PORTS)
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic [NUM_PORTS-1:0]          tent_req,
    input  logic [NUM_PORTS-1:0][PW-1:0]  pred_port,
    input  logic [NUM_PORTS-1:0]          flit_vld,
    input  logic [NUM_PORTS-1:0]          flit_head,
    input  logic [NUM_PORTS-1:0]          flit_tail,
    input  logic [NUM_PORTS-1:0][PW-1:0]  route,
    output logic [NUM_PORTS-1:0]          in_go,
    output logic [NUM_PORTS-1:0]          xbar_vld,
    output logic [NUM_PORTS-1:0][PW-1:0]  xbar_sel,
    output logic [NUM_PORTS-1:0]          kill
);
    localparam int NP = NUM_PORTS;

    logic [NP-1:0]         tent_vld, firm_vld, hold_vld, own_vld, drive_vld, kill_vld;
    logic [NP-1:0]         firm_won, tent_won, rsv_lost;
    logic [NP-1:0][PW-1:0] cur_port;
    // matrices indexed [output][input]
    logic [NP-1:0][NP-1:0] firm_m, tent_m, hold_m, own_m, fgnt_m, tgnt_m;
    logic [NP-1:0]         fpres;

    for (genvar gi = 0; gi < NP; gi++) begin : g_in
        sa_input_fsm #(.PW(PW)) u_fsm (
            .clk       (clk),
            .rst       (rst),
            .tent_req  (tent_req[gi]),
            .pred_port (pred_port[gi]),
            .flit_vld  (flit_vld[gi]),
            .flit_head (flit_head[gi]),
            .flit_tail (flit_tail[gi]),
            .route     (route[gi]),
            .firm_won  (firm_won[gi]),
            .tent_won  (tent_won[gi]),
            .rsv_lost  (rsv_lost[gi]),
            .tent_vld  (tent_vld[gi]),
            .firm_vld  (firm_vld[gi]),
            .hold_vld  (hold_vld[gi]),
            .own_vld   (own_vld[gi]),
            .drive_vld (drive_vld[gi]),
            .kill_vld  (kill_vld[gi]),
            .cur_port  (cur_port[gi])
        );
    end

    always_comb begin
        for (int o = 0; o < NP; o++) begin
            for (int i = 0; i < NP; i++) begin
                firm_m[o][i] = firm_vld[i] && (cur_port[i]  == PW'(o));
                hold_m[o][i] = hold_vld[i] && (cur_port[i]  == PW'(o));
                own_m[o][i]  = own_vld[i]  && (cur_port[i]  == PW'(o));
                tent_m[o][i] = tent_vld[i] && (pred_port[i] == PW'(o));
            end
        end
    end

    for (genvar go = 0; go < NP; go++) begin : g_out
        sa_out_arb #(.NP(NP), .PW(PW)) u_arb (
            .clk       (clk),
            .rst       (rst),
            .firm_req  (firm_m[go]),
            .tent_req  (tent_m[go]),
            .hold_req  (hold_m[go]),
            .own_req   (own_m[go]),
            .firm_gnt  (fgnt_m[go]),
            .tent_gnt  (tgnt_m[go]),
            .firm_pres (fpres[go])
        );
    end

    always_comb begin
        firm_won = '0;
        tent_won = '0;
        rsv_lost = '0;
        for (int i = 0; i < NP; i++) begin
            for (int o = 0; o < NP; o++) begin
                if (fgnt_m[o][i])               firm_won[i] = 1'b1;
                if (tgnt_m[o][i])               tent_won[i] = 1'b1;
                if (hold_m[o][i] && fpres[o])   rsv_lost[i] = 1'b1;
            end
        end
    end

    always_comb begin
        xbar_vld = '0;
        xbar_sel = '0;
        kill     = '0;
        for (int o = 0; o < NP; o++) begin
            for (int i = 0; i < NP; i++) begin
                if (drive_vld[i] && (cur_port[i] == PW'(o))) begin
                    xbar_vld[o] = 1'b1;
                    xbar_sel[o] = PW'(i);
                end
                if (kill_vld[i] && (cur_port[i] == PW'(o))) kill[o] = 1'b1;
            end
        end
    end

    assign in_go = drive_vld;
endmodule

// File: rtl/sa_checker.sv
module sa_checker #(
    parameter int NP = 5
) (
    input logic          clk,
    input logic          rst,
    input logic [NP-1:0] flit_vld,
    input logic [NP-1:0] in_go,
    input logic [NP-1:0] xbar_vld,
    input logic [NP-1:0] kill
);
    a_r1_quiet_after_reset: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (in_go == '0 && xbar_vld == '0 && kill == '0));

    a_r7_one_driver_per_column: assert property (@(posedge clk) disable iff (rst)
        $countones(in_go) == $countones(xbar_vld));

    for (genvar o = 0; o < NP; o++) begin : g_o
        a_r5_kill_single_cycle: assert property (@(posedge clk) disable iff (rst)
            kill[o] |=> !kill[o]);
        a_r5_kill_after_crossing: assert property (@(posedge clk) disable iff (rst)
            kill[o] |-> $past(xbar_vld[o]));
    end

    for (genvar i = 0; i < NP; i++) begin : g_i
        a_r8_go_needs_flit: assert property (@(posedge clk) disable iff (rst)
            in_go[i] |-> flit_vld[i]);
    end
endmodule

bind spec_sw_alloc sa_checker #(.NP(NUM_PORTS)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .flit_vld (flit_vld),
    .in_go    (in_go),
    .xbar_vld (xbar_vld),
    .kill     (kill)
);

// File: tb/sim_spec_sw_alloc.sv
module sim_spec_sw_alloc;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic [4:0]      treq, fv, fh, ft;
    logic [4:0][2:0] pred, rt;
    logic [4:0]      in_go, xbar_vld, kill;
    logic [4:0][2:0] xbar_sel;

    int n_chk  = 0;
    int n_fail = 0;

    // reference model state: 0 idle, 1 reserved, 2 verify, 3 route, 4 request, 5 stream
    int ms[5], mp[5], mt[5], mptr[5];
    int ns[5], nq[5], nt[5], nptr[5];
    logic [4:0]      e_go, e_xv, e_kill;
    logic [4:0][2:0] e_xs;

    always #5 clk = ~clk;

    spec_sw_alloc u0 (
        .clk(clk), .rst(rst), .tent_req(treq), .pred_port(pred),
        .flit_vld(fv), .flit_head(fh), .flit_tail(ft), .route(rt),
        .in_go(in_go), .xbar_vld(xbar_vld), .xbar_sel(xbar_sel), .kill(kill)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic clr();
        treq = '0; fv = '0; fh = '0; ft = '0; pred = '0; rt = '0;
    endtask

    task automatic model_reset();
        for (int i = 0; i < 5; i++) begin
            ms[i] = 0; mp[i] = 0; mt[i] = 0; mptr[i] = 0;
        end
    endtask

    task automatic model_eval();
        int busy[5];
        int held[5];
        int fw[5];
        int tw[5];
        e_go = '0; e_xv = '0; e_xs = '0; e_kill = '0;
        for (int o = 0; o < 5; o++) begin
            busy[o] = 0; held[o] = 0; fw[o] = -1; tw[o] = -1;
            for (int i = 0; i < 5; i++) begin
                if ((ms[i] == 2 || ms[i] == 5) && mp[i] == o) busy[o] = 1;
                if (ms[i] == 1 && mp[i] == o) held[o] = 1;
            end
            nptr[o] = mptr[o];
            if (busy[o] == 0) begin
                for (int k = 0; k < 5; k++) begin
                    int j;
                    j = (mptr[o] + k) % 5;
                    if (ms[j] == 4 && mp[j] == o && fw[o] < 0) fw[o] = j;
                end
                if (fw[o] >= 0) nptr[o] = (fw[o] + 1) % 5;
                else if (held[o] == 0) begin
                    for (int k = 0; k < 5; k++) begin
                        int j;
                        j = (mptr[o] + k) % 5;
                        if (ms[j] == 0 && treq[j] && !(fv[j] && fh[j]) &&
                            int'(pred[j]) == o && tw[o] < 0) tw[o] = j;
                    end
                end
            end
        end
        for (int i = 0; i < 5; i++) begin
            ns[i] = ms[i]; nq[i] = mp[i]; nt[i] = mt[i];
            case (ms[i])
                0: begin
                    if (fv[i] && fh[i]) ns[i] = 3;
                    else if (pred[i] < 5 && tw[pred[i]] == i) begin
                        ns[i] = 1; nq[i] = int'(pred[i]);
                    end
                end
                1: begin
                    if (fw[mp[i]] >= 0) ns[i] = (fv[i] && fh[i]) ? 3 : 0;
                    else if (fv[i] && fh[i]) begin
                        ns[i] = 2; nt[i] = int'(ft[i]);
                        e_go[i] = 1'b1; e_xv[mp[i]] = 1'b1; e_xs[mp[i]] = 3'(i);
                    end else if (!treq[i] || int'(pred[i]) != mp[i]) ns[i] = 0;
                end
                2: begin
                    if (int'(rt[i]) == mp[i]) ns[i] = (mt[i] != 0) ? 0 : 5;
                    else begin
                        e_kill[mp[i]] = 1'b1; nq[i] = int'(rt[i]); ns[i] = 4;
                    end
                end
                3: begin nq[i] = int'(rt[i]); ns[i] = 4; end
                4: if (fw[mp[i]] == i) ns[i] = 5;
                default: begin
                    if (fv[i]) begin
                        e_go[i] = 1'b1; e_xv[mp[i]] = 1'b1; e_xs[mp[i]] = 3'(i);
                        if (ft[i]) ns[i] = 0;
                    end
                end
            endcase
        end
    endtask

    // compare against the model, then advance one clock
    task automatic cyc();
        #1;
        model_eval();
        chk(in_go == e_go, "R8 in_go vs model", int'(in_go), int'(e_go));
        chk(xbar_vld == e_xv, "R7 xbar_vld vs model", int'(xbar_vld), int'(e_xv));
        for (int o = 0; o < 5; o++)
            if (e_xv[o]) chk(xbar_sel[o] == e_xs[o], "R7 xbar_sel vs model",
                             int'(xbar_sel[o]), int'(e_xs[o]));
        chk(kill == e_kill, "R5 kill vs model", int'(kill), int'(e_kill));
        @(posedge clk);
        #1;
        for (int i = 0; i < 5; i++) begin
            ms[i] = ns[i]; mp[i] = nq[i]; mt[i] = nt[i]; mptr[i] = nptr[i];
        end
        @(negedge clk);
    endtask

    initial begin
        #(10 * 200000);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end

    initial begin
        clr();
        treq = 5'b11111; fv = 5'b11111; fh = 5'b11111;
        repeat (3) @(posedge clk);
        #1;
        chk(in_go == 0 && xbar_vld == 0 && kill == 0, "R1 outputs during reset",
            int'(xbar_vld), 0);
        @(negedge clk);
        rst = 1'b0;
        clr();
        model_reset();
        #1;
        chk(in_go == 0 && xbar_vld == 0 && kill == 0, "R1 outputs after reset",
            int'(xbar_vld), 0);
        cyc();

        // speculative hit, three-flit packet on east (R2, R4)
        treq[0] = 1; pred[0] = 3'd1; cyc();
        fv[0] = 1; fh[0] = 1; #1;
        chk(in_go[0] && xbar_vld[1] && xbar_sel[1] == 0, "R2 head crosses on arrival",
            int'(xbar_sel[1]), 0);
        cyc();
        treq[0] = 0; fh[0] = 0; rt[0] = 3'd1; #1;
        chk(kill == 0, "R4 no kill on hit", int'(kill), 0);
        chk(in_go[0] == 0, "R4 no crossing in verify cycle", int'(in_go[0]), 0);
        cyc();
        #1;
        chk(in_go[0] && xbar_vld[1] && xbar_sel[1] == 0, "R4 body keeps output",
            int'(in_go[0]), 1);
        cyc();
        ft[0] = 1; #1;
        chk(in_go[0] == 1, "R8 tail crosses", int'(in_go[0]), 1);
        cyc();
        clr(); #1;
        chk(xbar_vld == 0, "R8 output released after tail", int'(xbar_vld), 0);
        cyc();

        // speculative miss: west predicts north, real route south (R5, R6)
        treq[2] = 1; pred[2] = 3'd3; cyc();
        fv[2] = 1; fh[2] = 1; ft[2] = 1; #1;
        chk(in_go[2] && xbar_vld[3] && xbar_sel[3] == 2, "R2 speculative crossing",
            int'(xbar_sel[3]), 2);
        cyc();
        treq[2] = 0; rt[2] = 3'd4; #1;
        chk(kill == 5'b01000, "R5 kill on wrong port", int'(kill), 8);
        chk(in_go == 0, "R5 no crossing in kill cycle", int'(in_go), 0);
        cyc();
        #1;
        chk(kill == 0, "R5 kill lasts one cycle", int'(kill), 0);
        chk(in_go[2] == 0, "R6 waits during allocation", int'(in_go[2]), 0);
        cyc();
        #1;
        chk(in_go[2] && xbar_vld[4] && xbar_sel[4] == 2, "R6 resent on correct port",
            int'(xbar_sel[4]), 2);
        chk(xbar_vld[3] == 0, "R6 wrong port not reused", int'(xbar_vld[3]), 0);
        cyc();
        clr(); cyc();

        // withdrawal of a reservation by a firm request (R3)
        treq[1] = 1; pred[1] = 3'd2; fv[3] = 1; fh[3] = 1; ft[3] = 1; cyc();
        rt[3] = 3'd2; cyc();
        fv[1] = 1; fh[1] = 1; ft[1] = 1; #1;
        chk(in_go[1] == 0, "R3 withdrawn holder does not cross", int'(in_go[1]), 0);
        chk(xbar_vld[2] == 0, "R3 column idle during firm grant", int'(xbar_vld[2]), 0);
        cyc();
        treq[1] = 0; rt[1] = 3'd0; #1;
        chk(in_go[3] && xbar_sel[2] == 3, "R3 firm requester owns output",
            int'(xbar_sel[2]), 3);
        cyc();
        fv[3] = 0; cyc();
        #1;
        chk(in_go[1] && xbar_vld[0] && xbar_sel[0] == 1, "R6 normal path three cycles",
            int'(xbar_sel[0]), 1);
        cyc();
        clr(); cyc();

        // round-robin order and wormhole hold on north (R9, R8)
        fv[2] = 1; fh[2] = 1; ft[2] = 1; cyc();
        rt[2] = 3'd3; fv[0] = 1; fh[0] = 1; ft[0] = 1; fv[4] = 1; fh[4] = 1; cyc();
        rt[0] = 3'd3; rt[4] = 3'd3; cyc();
        #1;
        chk(in_go[2] && xbar_sel[3] == 2, "R9 lone requester wins", int'(xbar_sel[3]), 2);
        chk(in_go[0] == 0 && in_go[4] == 0, "R8 others wait while owned", int'(in_go), 4);
        cyc();
        fv[2] = 0; cyc();
        #1;
        chk(in_go[4] && xbar_sel[3] == 4, "R9 pointer order picks input 4",
            int'(xbar_sel[3]), 4);
        chk(in_go[0] == 0, "R9 input 0 loses", int'(in_go[0]), 0);
        cyc();
        fh[4] = 0; ft[4] = 1; #1;
        chk(in_go[4] && !in_go[0], "R8 owner keeps output", int'(in_go), 16);
        cyc();
        fv[4] = 0; #1;
        chk(xbar_vld[3] == 0, "R8 free after tail", int'(xbar_vld[3]), 0);
        cyc();
        #1;
        chk(in_go[0] && xbar_sel[3] == 0, "R9 waiting input served next",
            int'(xbar_sel[3]), 0);
        cyc();
        clr(); cyc();

        // random traffic compared against the model every cycle
        for (int n = 0; n < 3000; n++) begin
            for (int i = 0; i < 5; i++) begin
                treq[i] = ($urandom % 3) != 0;
                pred[i] = 3'($urandom % 5);
                rt[i]   = 3'($urandom % 5);
                fv[i]   = ($urandom % 4) != 0;
                fh[i]   = ($urandom % 3) == 0;
                ft[i]   = ($urandom % 3) == 0;
            end
            cyc();
        end

        $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end
endmodule